// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block decodes a small I/O window that holds the bus-master DMA control registers of two disk channels. Each channel owns an eight-byte slice of the window. The lower four bytes of a slice are byte registers: a command byte, a view of the interrupt mode register that both channels share, a status byte and a timing byte for that channel. The upper four bytes hold a 32-bit descriptor-table address. Each access carries an address, a size code and, for writes, data. The read data is produced combinationally from the address and the size, and a write takes effect on the next clock edge.

The command bytes and descriptor addresses go out to a DMA engine. That engine reports back through an active level and through error and interrupt pulses, which land in the status byte. Each channel's drive interrupt level is registered into the shared mode register. The mode register also holds a mask bit for each channel, and the block merges the unmasked levels into one interrupt output. Status bits 2 and 1 clear when software writes a one to them, bits 6 and 5 are plain storage, and bit 0 follows the engine.

Top module: `bmdma_regwin`

## Requirements
- R1: Channel n occupies window offsets 8n to 8n+7. Within a slice, byte offset 0 is the command byte, 1 the shared mode register, 2 the status byte and 3 the timing byte. A single-byte read (size code 0) returns the byte in bits 7:0 with bits 31:8 zero.
- R2: At offsets 0 to 3 of a slice, only size code 0 is honoured. A read with size code 1 returns 0x0000FFFF, a read with size code 2 or 3 returns 0xFFFFFFFF, and a write with any size code other than 0 changes no register.
- R3: Mode register layout: bit 2+n holds channel n's drive interrupt level, registered one cycle after `ide_irq`. Bit 4+n is channel n's mask. All other bits read zero. A byte write at offset 1 of either slice loads only bits 5 and 4.
- R4: `irq_out` is high exactly when some channel n has level bit 2+n set and mask bit 4+n clear. `mirror_irq[n]` equals level bit 2+n, whatever the mask.
- R5: A status write loads bits 6 and 5 from the data and clears bit 2 or bit 1 where the data bit is one; other written bits have no effect, and bits 7, 4 and 3 always read zero.
- R6: Status bit 0 reads the channel's `eng_active` input. A one-cycle pulse on `eng_err_set` sets bit 1 and a pulse on `eng_intr_set` sets bit 2. A set pulse wins over a clearing write in the same cycle.
- R7: Each channel's timing byte is stored as written, reads back at offset 3 of that channel's slice and drives `timing_out[8n+7:8n]`.
- R8: At offset 4 of a slice, a size-2 access reads or writes the descriptor address, and a write forces bits 1:0 to zero. Any other access to offsets 4 to 7 reads all ones (0xFF for size 0) and is ignored as a write. The address drives `dma_prd_addr[32n+31:32n]`.
- R9: Reset, synchronous and active high, clears every register: command, status, timing, descriptor address, mask and level bits.
- R10: Each channel's command byte is stored as written and drives `dma_cmd[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe for the current cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset inside the window |
| acc_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 reserved |
| acc_wdata | input | 32 | Write data, byte in bits 7:0 |
| acc_rdata | output | 32 | Read data for the presented address and size |
| eng_active | input | 2 | Per-channel engine busy level (status bit 0) |
| eng_err_set | input | 2 | Per-channel error pulse (sets status bit 1) |
| eng_intr_set | input | 2 | Per-channel interrupt pulse (sets status bit 2) |
| ide_irq | input | 2 | Per-channel drive interrupt level |
| dma_cmd | output | 16 | Command bytes, channel n in bits 8n+7:8n |
| dma_prd_addr | output | 64 | Descriptor addresses, channel n in bits 32n+31:32n |
| timing_out | output | 16 | Timing bytes, channel n in bits 8n+7:8n |
| mirror_irq | output | 2 | Registered per-channel interrupt levels |
| irq_out | output | 1 | Merged unmasked interrupt |

## Verification
Every cycle, the assertions check the following. Reset clears the command outputs and the interrupt. The status bits that are never written stay zero. An error or interrupt pulse sets its status bit on the next edge. Wide writes to the byte registers leave the command and timing outputs alone. `irq_out` never rises without a level bit set. The scenarios cover the rest: the exact merge of data and current value in a status write, a set pulse and a clear arriving together, the mask-only write into the shared mode register from either slice, and the all-ones values returned for rejected sizes and offsets. None of these can be checked without a known history of writes.

// File: rtl/bmw_pkg.sv
package bmw_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int SLICE_BYTES  = 8;
    localparam int MODE_LVL_LSB = 2;
    localparam int MODE_MSK_LSB = 4;
    localparam int ST_ERR       = 1;
    localparam int ST_INT       = 2;
    localparam logic [7:0] ST_KEEP_MASK = 8'h60;
    localparam logic [7:0] ST_W1C_MASK  = 8'h06;

    typedef struct packed {
        logic        wr_cmd;
        logic        wr_stat;
        logic        wr_tim;
        logic        wr_prd;
        logic [31:0] wdata;
    } chan_wr_t;

    function automatic logic [31:0] ones_for_size(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: ones_for_size = 32'h0000_00FF;
            SZ_HALF: ones_for_size = 32'h0000_FFFF;
            default: ones_for_size = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [7:1] status_next(
        input logic [7:0] cur,
        input logic       we,
        input logic [7:0] wd,
        input logic       err,
        input logic       intr
    );
        logic [7:0] s;
        s = cur;
        if (we)
            s = (wd & ST_KEEP_MASK) | (cur & ~wd & ST_W1C_MASK);
        if (err)
            s[ST_ERR] = 1'b1;
        if (intr)
            s[ST_INT] = 1'b1;
        status_next = s[7:1];
    endfunction

endpackage

// File: rtl/bmw_chan.sv
module bmw_chan
    import bmw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  chan_wr_t    wr,
    input  logic        eng_active,
    input  logic        err_set,
    input  logic        intr_set,
    output logic [7:0]  cmd_q,
    output logic [7:0]  stat_rd,
    output logic [7:0]  tim_q,
    output logic [31:0] prd_q
);

    logic [7:1] stat_hi_q;

    assign stat_rd = {stat_hi_q, eng_active};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            tim_q     <= '0;
            prd_q     <= '0;
            stat_hi_q <= '0;
        end else begin
            if (wr.wr_cmd)
                cmd_q <= wr.wdata[7:0];
            if (wr.wr_tim)
                tim_q <= wr.wdata[7:0];
            if (wr.wr_prd)
                prd_q <= {wr.wdata[31:2], 2'b00};
            stat_hi_q <= status_next(stat_rd, wr.wr_stat, wr.wdata[7:0],
                                     err_set, intr_set);
        end
    end

endmodule

// File: rtl/bmw_mode.sv
module bmw_mode
    import bmw_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic [NUM_CH-1:0] mask_wdata,
    input  logic [NUM_CH-1:0] ide_irq,
    output logic [7:0]        mode_byte,
    output logic [NUM_CH-1:0] lvl_out,
    output logic              irq_out
);

    logic [NUM_CH-1:0] lvl_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] live;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            mask_q <= '0;
        end else begin
            lvl_q <= ide_irq;
            if (mask_we)
                mask_q <= mask_wdata;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_live
        assign live[g] = lvl_q[g] & ~mask_q[g];
    end

    always_comb begin
        mode_byte = '0;
        mode_byte[MODE_LVL_LSB +: NUM_CH] = lvl_q;
        mode_byte[MODE_MSK_LSB +: NUM_CH] = mask_q;
    end

    assign lvl_out = lvl_q;
    assign irq_out = |live;

endmodule

// File: rtl/bmdma_regwin.sv
module bmdma_regwin
    import bmw_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = $clog2(NUM_CH * SLICE_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [1:0]           acc_size,
    input  logic [31:0]          acc_wdata,
    output logic [31:0]          acc_rdata,
    input  logic [NUM_CH-1:0]    eng_active,
    input  logic [NUM_CH-1:0]    eng_err_set,
    input  logic [NUM_CH-1:0]    eng_intr_set,
    input  logic [NUM_CH-1:0]    ide_irq,
    output logic [NUM_CH*8-1:0]  dma_cmd,
    output logic [NUM_CH*32-1:0] dma_prd_addr,
    output logic [NUM_CH*8-1:0]  timing_out,
    output logic [NUM_CH-1:0]    mirror_irq,
    output logic                 irq_out
);

    localparam int CH_W = ADDR_W - 3;

    logic [CH_W-1:0] ch_sel;
    logic [2:0]      off;
    logic            is_byte;
    logic            is_word;
    logic            ch_ok;
    logic            wr_go;

    logic [7:0]  cmd_a  [NUM_CH];
    logic [7:0]  stat_a [NUM_CH];
    logic [7:0]  tim_a  [NUM_CH];
    logic [31:0] prd_a  [NUM_CH];
    chan_wr_t    wr_a   [NUM_CH];

    logic [NUM_CH*8-1:0] stat_all;
    logic [7:0]          mode_byte;
    logic                mask_we;

    assign ch_sel  = acc_addr[ADDR_W-1:3];
    assign off     = acc_addr[2:0];
    assign is_byte = (acc_size == SZ_BYTE);
    assign is_word = (acc_size == SZ_WORD);
    assign ch_ok   = (int'(ch_sel) < NUM_CH);
    assign wr_go   = acc_valid & acc_write & ch_ok;
    assign mask_we = wr_go & is_byte & (off == 3'd1);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = wr_go & (ch_sel == CH_W'(g));

        always_comb begin
            wr_a[g].wr_cmd  = hit & is_byte & (off == 3'd0);
            wr_a[g].wr_stat = hit & is_byte & (off == 3'd2);
            wr_a[g].wr_tim  = hit & is_byte & (off == 3'd3);
            wr_a[g].wr_prd  = hit & is_word & (off == 3'd4);
            wr_a[g].wdata   = acc_wdata;
        end

        bmw_chan u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr         (wr_a[g]),
            .eng_active (eng_active[g]),
            .err_set    (eng_err_set[g]),
            .intr_set   (eng_intr_set[g]),
            .cmd_q      (cmd_a[g]),
            .stat_rd    (stat_a[g]),
            .tim_q      (tim_a[g]),
            .prd_q      (prd_a[g])
        );

        assign dma_cmd[g*8 +: 8]        = cmd_a[g];
        assign timing_out[g*8 +: 8]     = tim_a[g];
        assign dma_prd_addr[g*32 +: 32] = prd_a[g];
        assign stat_all[g*8 +: 8]       = stat_a[g];
    end

    bmw_mode #(.NUM_CH(NUM_CH)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .mask_we    (mask_we),
        .mask_wdata (acc_wdata[MODE_MSK_LSB +: NUM_CH]),
        .ide_irq    (ide_irq),
        .mode_byte  (mode_byte),
        .lvl_out    (mirror_irq),
        .irq_out    (irq_out)
    );

    always_comb begin
        acc_rdata = ones_for_size(acc_size);
        if (ch_ok) begin
            if (!off[2]) begin
                if (is_byte) begin
                    case (off[1:0])
                        2'd0:    acc_rdata = {24'h0, cmd_a[ch_sel]};
                        2'd1:    acc_rdata = {24'h0, mode_byte};
                        2'd2:    acc_rdata = {24'h0, stat_a[ch_sel]};
                        default: acc_rdata = {24'h0, tim_a[ch_sel]};
                    endcase
                end
            end else if (is_word && off[1:0] == 2'd0) begin
                acc_rdata = prd_a[ch_sel];
            end
        end
    end

endmodule

// File: rtl/bmw_checker.sv
module bmw_checker #(
    parameter int NUM_CH = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                acc_valid,
    input logic                acc_write,
    input logic [2:0]          acc_off,
    input logic [1:0]          acc_size,
    input logic [NUM_CH-1:0]   eng_err_set,
    input logic [NUM_CH-1:0]   eng_intr_set,
    input logic [NUM_CH*8-1:0] stat_all,
    input logic [NUM_CH*8-1:0] dma_cmd,
    input logic [NUM_CH*8-1:0] timing_out,
    input logic [NUM_CH-1:0]   mirror_irq,
    input logic                irq_out
);

    logic wide_low_wr;
    logic tim_wr;

    assign wide_low_wr = acc_valid & acc_write & ~acc_off[2] & (acc_size != 2'd0);
    assign tim_wr      = acc_valid & acc_write & (acc_off == 3'd3) & (acc_size == 2'd0);

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (dma_cmd == '0 && timing_out == '0 && irq_out == 1'b0));

    assert_irq_needs_level_R4: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (mirror_irq != '0));

    assert_wide_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        wide_low_wr |=> ($stable(dma_cmd) && $stable(timing_out)));

    assert_timing_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !tim_wr |=> $stable(timing_out));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_st
        assert_status_zero_bits_R5: assert property (@(posedge clk) disable iff (rst)
            (stat_all[g*8+7] == 1'b0 && stat_all[g*8+4] == 1'b0 && stat_all[g*8+3] == 1'b0));

        assert_err_pulse_sets_R6: assert property (@(posedge clk) disable iff (rst)
            eng_err_set[g] |=> stat_all[g*8+1]);

        assert_intr_pulse_sets_R6: assert property (@(posedge clk) disable iff (rst)
            eng_intr_set[g] |=> stat_all[g*8+2]);
    end

endmodule

bind bmdma_regwin bmw_checker #(.NUM_CH(NUM_CH)) u_bmw_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_off      (acc_addr[2:0]),
    .acc_size     (acc_size),
    .eng_err_set  (eng_err_set),
    .eng_intr_set (eng_intr_set),
    .stat_all     (stat_all),
    .dma_cmd      (dma_cmd),
    .timing_out   (timing_out),
    .mirror_irq   (mirror_irq),
    .irq_out      (irq_out)
);

// File: tb/bmdma_regwin_bench.sv
module bmdma_regwin_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic [1:0]  eng_active = '0;
    logic [1:0]  eng_err_set = '0;
    logic [1:0]  eng_intr_set = '0;
    logic [1:0]  ide_irq = '0;
    logic [15:0] dma_cmd;
    logic [63:0] dma_prd_addr;
    logic [15:0] timing_out;
    logic [1:0]  mirror_irq;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bmdma_regwin u_bmdma_regwin (
        .clk          (clk),
        .rst          (rst),
        .acc_valid    (acc_valid),
        .acc_write    (acc_write),
        .acc_addr     (acc_addr),
        .acc_size     (acc_size),
        .acc_wdata    (acc_wdata),
        .acc_rdata    (acc_rdata),
        .eng_active   (eng_active),
        .eng_err_set  (eng_err_set),
        .eng_intr_set (eng_intr_set),
        .ide_irq      (ide_irq),
        .dma_cmd      (dma_cmd),
        .dma_prd_addr (dma_prd_addr),
        .timing_out   (timing_out),
        .mirror_irq   (mirror_irq),
        .irq_out      (irq_out)
    );

    // {req, write, addr, size, wdata, expected read data}
    localparam int NV = 18;
    localparam logic [78:0] VEC [NV] = '{
        {8'd10, 1'b1, 4'd0,  2'd0, 32'h0000_0009, 32'h0},          // R10 cmd ch0
        {8'd1,  1'b0, 4'd0,  2'd0, 32'h0,         32'h0000_0009},  // R1
        {8'd10, 1'b1, 4'd8,  2'd0, 32'hFFFF_FF81, 32'h0},          // R10 cmd ch1
        {8'd1,  1'b0, 4'd8,  2'd0, 32'h0,         32'h0000_0081},  // R1
        {8'd7,  1'b1, 4'd3,  2'd0, 32'h0000_00A5, 32'h0},          // R7
        {8'd7,  1'b1, 4'd11, 2'd0, 32'h0000_003C, 32'h0},          // R7
        {8'd7,  1'b0, 4'd3,  2'd0, 32'h0,         32'h0000_00A5},  // R7
        {8'd7,  1'b0, 4'd11, 2'd0, 32'h0,         32'h0000_003C},  // R7
        {8'd8,  1'b1, 4'd4,  2'd2, 32'h1234_5677, 32'h0},          // R8
        {8'd8,  1'b0, 4'd4,  2'd2, 32'h0,         32'h1234_5674},  // R8
        {8'd8,  1'b1, 4'd12, 2'd2, 32'hFFFF_FFFF, 32'h0},          // R8
        {8'd8,  1'b0, 4'd12, 2'd2, 32'h0,         32'hFFFF_FFFC},  // R8
        {8'd8,  1'b0, 4'd5,  2'd0, 32'h0,         32'h0000_00FF},  // R8 byte read high half
        {8'd2,  1'b0, 4'd0,  2'd1, 32'h0,         32'h0000_FFFF},  // R2
        {8'd2,  1'b0, 4'd2,  2'd2, 32'h0,         32'hFFFF_FFFF},  // R2
        {8'd2,  1'b1, 4'd0,  2'd1, 32'h0000_00FF, 32'h0},          // R2 ignored
        {8'd2,  1'b0, 4'd0,  2'd0, 32'h0,         32'h0000_0009},  // R2 unchanged
        {8'd8,  1'b1, 4'd6,  2'd0, 32'h0000_0055, 32'h0}           // R8 ignored
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = s; acc_wdata = d;
        @(posedge clk);
        #1 acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [1:0] s,
                      input logic [31:0] exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = s;
        #1 chk(req, {32'h0, acc_rdata}, {32'h0, exp});
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R9: reset state
        rd("R9", 4'd0, 2'd0, 32'h0);
        rd("R9", 4'd1, 2'd0, 32'h0);
        rd("R9", 4'd10, 2'd0, 32'h0);
        rd("R9", 4'd4, 2'd2, 32'h0);
        chk("R9", {47'h0, irq_out, dma_cmd}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VEC[i][78:71]);
            if (VEC[i][70])
                wr(VEC[i][69:66], VEC[i][65:64], VEC[i][63:32]);
            else
                rd(tag, VEC[i][69:66], VEC[i][65:64], VEC[i][31:0]);
        end
        chk("R10", {48'h0, dma_cmd}, 64'h8109);
        chk("R7",  {48'h0, timing_out}, 64'h3CA5);
        chk("R8",  dma_prd_addr, 64'hFFFF_FFFC_1234_5674);

        // R5 / R6 status behaviour on channel 0
        wr(4'd2, 2'd0, 32'h66);
        rd("R5", 4'd2, 2'd0, 32'h60);
        @(negedge clk); eng_err_set = 2'b01; @(negedge clk); eng_err_set = 2'b00;
        rd("R6", 4'd2, 2'd0, 32'h62);
        @(negedge clk); eng_intr_set = 2'b01; @(negedge clk); eng_intr_set = 2'b00;
        rd("R6", 4'd2, 2'd0, 32'h66);
        eng_active = 2'b01;
        rd("R6", 4'd2, 2'd0, 32'h67);
        wr(4'd2, 2'd0, 32'h02);
        rd("R5", 4'd2, 2'd0, 32'h05);
        // set pulse beats a clearing write in the same cycle
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'd2; acc_size = 2'd0;
        acc_wdata = 32'h04; eng_intr_set = 2'b01;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; eng_intr_set = 2'b00;
        rd("R6", 4'd2, 2'd0, 32'h05);
        rd("R5", 4'd10, 2'd0, 32'h00);
        eng_active = 2'b00;

        // R3 / R4 shared mode register and interrupt merge
        @(negedge clk); ide_irq = 2'b01;
        @(negedge clk);
        chk("R4", {61'h0, mirror_irq, irq_out}, 64'h3);
        rd("R3", 4'd1, 2'd0, 32'h04);
        wr(4'd1, 2'd0, 32'h10);
        chk("R4", {63'h0, irq_out}, 64'h0);
        rd("R3", 4'd1, 2'd0, 32'h14);
        @(negedge clk); ide_irq = 2'b11;
        @(negedge clk);
        chk("R4", {61'h0, mirror_irq, irq_out}, 64'h7);
        wr(4'd9, 2'd0, 32'h30);
        chk("R4", {63'h0, irq_out}, 64'h0);
        rd("R3", 4'd1, 2'd0, 32'h3C);
        wr(4'd1, 2'd0, 32'hCF);
        rd("R3", 4'd9, 2'd0, 32'h0C);
        chk("R4", {63'h0, irq_out}, 64'h1);
        @(negedge clk); ide_irq = 2'b00;
        @(negedge clk);
        chk("R4", {61'h0, mirror_irq, irq_out}, 64'h0);

        // R9: reset in the middle of operation
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R9", {32'h0, timing_out, dma_cmd}, 64'h0);
        rd("R9", 4'd12, 2'd2, 32'h0);
        rd("R9", 4'd2, 2'd0, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R9 actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule